// File: doc/BRIEF.md
# Narrow Write Beat Packer

This block sits on the write path between a narrow bus-side master and a fixed 64-bit internal interface. Cacheable, incrementing write beats that are narrower than 64 bits are packed into full wide beats. Each incoming byte goes to the wide byte lane selected by the low three address bits. Merging is driven by beat size, not by bus width: on a 32-bit side, four 2-byte beats or two 4-byte beats can form one 64-bit beat. Noncacheable beats, and all beats while the merge-disable input is high, pass through one wide beat per narrow beat, still placed in the correct lanes.

The downstream side returns one write response for each wide beat. The block folds these back into a single response per upstream burst. The folded response is the one with the highest priority among those collected. While merge-disable is high, responses are instead forwarded one for one. An upstream exclusive write that ends up as more than one downstream beat loses its exclusive flag.

Every beat carries address, size (log2 of the byte count), data, byte strobes, last, cacheable and exclusive flags. Addresses are assumed aligned to the beat size. The merge-disable input is assumed to change only between bursts.

Top module: `narrow_write_packer`

## Requirements
- R1: With `merge_off`=0 and `s_cache`=1, contiguous beats that fall in the same 8-byte word are packed into one output beat. Each byte lands in wide lane `addr[2:0]`+k, where k is its index within the beat. An output strobe bit is set only where the byte lies inside the beat's size window (2^`s_size` bytes starting at `addr[2:0]`) and its input strobe, taken from narrow lane `addr % (IN_W/8)`+k, is set.
- R2: A partly filled wide beat is closed and offered on the output in three cases: when a beat with `s_last`=1 is absorbed, when an absorbed beat fills byte lane 7, or when the next presented beat is not at the next contiguous address in the same 8-byte word.
- R3: A beat with `s_cache`=0 is never merged. It produces its own output beat with its own address, size and lanes.
- R4: While `merge_off`=1, every input beat produces its own output beat. Every downstream response is then forwarded upstream unchanged, one for one.
- R5: `m_excl` is 1 only on an output beat that is the sole output beat of its burst, and only if the burst was exclusive. In every other case it is 0.
- R6: `m_last` is 1 only on the output beat that holds the final input beat of a burst.
- R7: With `merge_off`=0, exactly one upstream response is returned per input burst. Its value is the highest-priority downstream response of that burst. Priority from high to low is 2'b11 (decode error), 2'b10 (slave error), 2'b00 (okay), 2'b01 (exclusive okay).
- R8: `s_ready` is 0 while `m_valid` is 1. Output beat fields and `m_valid` hold while `m_ready` is 0. `s_bvalid`/`s_bresp` hold while `s_bready` is 0. No beat or response is lost or duplicated.
- R9: An output beat built from more than one input beat has `m_size`=3 and an address aligned down to 8 bytes. A beat from a single input beat keeps that beat's address and size.
- R10: After reset, `m_valid`=0, `s_bvalid`=0 and `s_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| merge_off | input | 1 | 1 disables data and response merging |
| s_valid | input | 1 | Narrow beat valid |
| s_ready | output | 1 | Narrow beat accepted |
| s_addr | input | AW | Byte address of the beat |
| s_size | input | 3 | log2 of the bytes in the beat |
| s_data | input | IN_W | Narrow write data |
| s_strb | input | IN_W/8 | Narrow byte strobes |
| s_last | input | 1 | Final beat of the burst |
| s_cache | input | 1 | Cacheable (mergeable) access |
| s_excl | input | 1 | Exclusive access |
| m_valid | output | 1 | Wide beat valid |
| m_ready | input | 1 | Wide beat accepted |
| m_addr | output | AW | Wide beat address |
| m_size | output | 3 | Wide beat size |
| m_data | output | 64 | Wide data |
| m_strb | output | 8 | Wide byte strobes |
| m_last | output | 1 | Beat holds the final input beat |
| m_cache | output | 1 | Cacheable flag passed on |
| m_excl | output | 1 | Exclusive flag after the split rule |
| m_bvalid | input | 1 | Downstream response valid |
| m_bready | output | 1 | Downstream response accepted |
| m_bresp | input | 2 | Downstream response code |
| s_bvalid | output | 1 | Upstream response valid |
| s_bready | input | 1 | Upstream response accepted |
| s_bresp | output | 2 | Upstream response code |

## Verification
The bench builds the block with a 32-bit narrow side, a 16-bit address and a response queue of depth 4. The 32-bit width allows 2-byte beats that pack four to a wide beat and 4-byte beats that pack two to a wide beat. Both halves of the replicated narrow word are therefore exercised. The depth of 4 covers a four-beat noncacheable burst whose responses must all be folded into one. The short address keeps the directed address patterns readable while still crossing 8-byte boundaries.

// File: rtl/nwp_pkg.sv
// Shared response codes and the priority function used by the response fold.
package nwp_pkg;
    localparam logic [1:0] RSP_OKAY   = 2'b00;
    localparam logic [1:0] RSP_EXOKAY = 2'b01;
    localparam logic [1:0] RSP_SLVERR = 2'b10;
    localparam logic [1:0] RSP_DECERR = 2'b11;

    // Rank of a response: larger wins when several are folded into one.
    function automatic logic [1:0] rsp_rank(input logic [1:0] r);
        case (r)
            RSP_DECERR: return 2'd3;
            RSP_SLVERR: return 2'd2;
            RSP_OKAY:   return 2'd1;
            default:    return 2'd0;
        endcase
    endfunction

    // Pick the higher-priority of two responses.
    function automatic logic [1:0] rsp_worse(input logic [1:0] a, input logic [1:0] b);
        return (rsp_rank(a) >= rsp_rank(b)) ? a : b;
    endfunction
endpackage

// File: rtl/nwp_lane_place.sv
// Places one narrow beat onto the 64-bit lane grid.
// Assumes: IN_W is 8, 16, 32 or 64 and the address is aligned to the beat size.
// Outputs the replicated data, the masked strobes, a per-bit lane mask,
// the byte count and whether the beat reaches byte lane 7.
module nwp_lane_place #(
    parameter int IN_W = 32
) (
    input  logic [2:0]        lo_addr,
    input  logic [2:0]        size,
    input  logic [IN_W-1:0]   data,
    input  logic [IN_W/8-1:0] strb,
    output logic [63:0]       w_data,
    output logic [7:0]        w_strb,
    output logic [63:0]       w_bmask,
    output logic [3:0]        nbytes,
    output logic              ends_word
);
    localparam int NB_IN  = IN_W / 8;
    localparam int REP    = 8 / NB_IN;
    localparam int SZ_MAX = $clog2(NB_IN);

    logic [2:0] eff_size;
    logic [3:0] lo_ext;
    logic [7:0] lanes;

    // Clamp the size to the narrow bus width and derive the byte count.
    always_comb begin
        eff_size  = (size > 3'(SZ_MAX)) ? 3'(SZ_MAX) : size;
        nbytes    = 4'd1 << eff_size;
        lo_ext    = {1'b0, lo_addr};
        ends_word = ((lo_ext + nbytes) == 4'd8);
    end

    // Narrow lanes repeat across the wide word, so each wide lane sees its byte.
    assign w_data = {REP{data}};

    for (genvar j = 0; j < 8; j++) begin : g_lane
        localparam logic [3:0] LJ = 4'(j);
        assign lanes[j]             = (LJ >= lo_ext) && (LJ < (lo_ext + nbytes));
        assign w_strb[j]            = lanes[j] & strb[j % NB_IN];
        assign w_bmask[8*j +: 8]    = {8{lanes[j]}};
    end
endmodule

// File: rtl/nwp_packer.sv
// Accumulates narrow beats into one wide beat and presents it on the output.
// Assumes: incrementing bursts, size-aligned addresses, merge_off stable in a burst.
// A partial beat closes on last, on filling lane 7, or when the next beat
// cannot join it; the input stalls while a closed beat waits.
module nwp_packer #(
    parameter int IN_W = 32,
    parameter int AW   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              merge_off,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [AW-1:0]     s_addr,
    input  logic [2:0]        s_size,
    input  logic [IN_W-1:0]   s_data,
    input  logic [IN_W/8-1:0] s_strb,
    input  logic              s_last,
    input  logic              s_cache,
    input  logic              s_excl,
    output logic              q_done,
    input  logic              q_take,
    output logic [AW-1:0]     q_addr,
    output logic [2:0]        q_size,
    output logic [63:0]       q_data,
    output logic [7:0]        q_strb,
    output logic              q_last,
    output logic              q_cache,
    output logic              q_excl,
    output logic              q_byp
);
    logic [63:0]   p_data, p_bmask;
    logic [7:0]    p_strb;
    logic [3:0]    p_n;
    logic          p_end;

    logic          busy, done, multi, mid;
    logic          a_cache, a_excl, a_first, a_last, a_byp;
    logic [AW-1:0] a_addr, a_next;
    logic [2:0]    a_size;
    logic [63:0]   a_data;
    logic [7:0]    a_strb;

    logic          mergeable_in, can_merge, accept, fin;

    nwp_lane_place #(.IN_W(IN_W)) u_place (
        .lo_addr   (s_addr[2:0]),
        .size      (s_size),
        .data      (s_data),
        .strb      (s_strb),
        .w_data    (p_data),
        .w_strb    (p_strb),
        .w_bmask   (p_bmask),
        .nbytes    (p_n),
        .ends_word (p_end)
    );

    // Decide whether the presented beat joins the partial beat or forces a flush.
    always_comb begin
        mergeable_in = s_cache && !merge_off;
        can_merge    = busy && !done && mergeable_in &&
                       (s_addr == a_next) && (s_addr[AW-1:3] == a_addr[AW-1:3]);
        s_ready      = !busy || can_merge;
        accept       = s_valid && s_ready;
        fin          = s_last || !mergeable_in || p_end;
    end

    // Accumulator state: load, merge, flush and release to the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            multi   <= 1'b0;
            mid     <= 1'b0;
            a_cache <= 1'b0;
            a_excl  <= 1'b0;
            a_first <= 1'b0;
            a_last  <= 1'b0;
            a_byp   <= 1'b0;
            a_addr  <= '0;
            a_next  <= '0;
            a_size  <= '0;
            a_data  <= '0;
            a_strb  <= '0;
        end else begin
            if (q_take) begin
                busy <= 1'b0;
                done <= 1'b0;
            end else if (accept && !busy) begin
                busy    <= 1'b1;
                done    <= fin;
                multi   <= 1'b0;
                a_data  <= p_data;
                a_strb  <= p_strb;
                a_addr  <= s_addr;
                a_next  <= s_addr + AW'(p_n);
                a_size  <= s_size;
                a_cache <= s_cache;
                a_excl  <= s_excl;
                a_first <= !mid;
                a_last  <= s_last;
                a_byp   <= merge_off;
            end else if (accept) begin
                done    <= fin;
                multi   <= 1'b1;
                a_data  <= (a_data & ~p_bmask) | (p_data & p_bmask);
                a_strb  <= a_strb | p_strb;
                a_next  <= a_next + AW'(p_n);
                a_last  <= s_last;
            end else if (s_valid && busy && !done) begin
                done    <= 1'b1;
            end
            if (accept) begin
                mid <= !s_last;
            end
        end
    end

    // Present the closed beat; a packed beat reports a full aligned word.
    always_comb begin
        q_done  = done;
        q_addr  = multi ? {a_addr[AW-1:3], 3'b000} : a_addr;
        q_size  = multi ? 3'd3 : a_size;
        q_data  = a_data;
        q_strb  = a_strb;
        q_last  = a_last;
        q_cache = a_cache;
        q_excl  = a_excl && a_first && a_last;
        q_byp   = a_byp;
    end
endmodule

// File: rtl/nwp_flag_fifo.sv
// Small first-in first-out queue of per-beat flags.
// Assumes: DEPTH is a power of two and at least 2; no push when full,
// no pop when empty.
module nwp_flag_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [PW:0]  wp, rp;

    // Pointer update with wrap bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wp[PW-1:0]] <= din;
    end

    assign dout  = mem[rp[PW-1:0]];
    assign empty = (wp == rp);
    assign full  = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
endmodule

// File: rtl/nwp_resp_fold.sv
// Folds downstream per-beat write responses into upstream responses.
// Each issued wide beat leaves a flag pair {last-of-burst, forward}; a
// forward beat returns its response alone, otherwise responses of a burst
// are reduced by priority and returned when its last beat answers.
// Assumes: downstream answers in order and only for beats already issued.
module nwp_resp_fold #(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic       push_last,
    input  logic       push_fwd,
    output logic       full,
    input  logic       m_bvalid,
    output logic       m_bready,
    input  logic [1:0] m_bresp,
    output logic       s_bvalid,
    input  logic       s_bready,
    output logic [1:0] s_bresp
);
    import nwp_pkg::*;

    logic [1:0] head;
    logic       empty, pop, hold_v, emit;
    logic [1:0] hold_r, folded;

    nwp_flag_fifo #(.DEPTH(DEPTH), .W(2)) u_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   ({push_last, push_fwd}),
        .pop   (pop),
        .dout  (head),
        .full  (full),
        .empty (empty)
    );

    // Accept a response only when one is owed and the upstream slot is free.
    always_comb begin
        m_bready = !empty && (!s_bvalid || s_bready);
        pop      = m_bvalid && m_bready;
        folded   = hold_v ? rsp_worse(hold_r, m_bresp) : m_bresp;
        emit     = head[1] || head[0];
    end

    // Running worst response and upstream response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v   <= 1'b0;
            hold_r   <= RSP_OKAY;
            s_bvalid <= 1'b0;
            s_bresp  <= RSP_OKAY;
        end else begin
            if (s_bvalid && s_bready) s_bvalid <= 1'b0;
            if (pop) begin
                if (emit) begin
                    s_bvalid <= 1'b1;
                    s_bresp  <= folded;
                    hold_v   <= 1'b0;
                end else begin
                    hold_v   <= 1'b1;
                    hold_r   <= folded;
                end
            end
        end
    end
endmodule

// File: rtl/narrow_write_packer.sv
// Top level: narrow write beats in, packed 64-bit beats out, folded
// responses back. Assumes size-aligned incrementing bursts and that
// merge_off changes only between bursts.
module narrow_write_packer #(
    parameter int IN_W     = 32,
    parameter int AW       = 32,
    parameter int RQ_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              merge_off,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [AW-1:0]     s_addr,
    input  logic [2:0]        s_size,
    input  logic [IN_W-1:0]   s_data,
    input  logic [IN_W/8-1:0] s_strb,
    input  logic              s_last,
    input  logic              s_cache,
    input  logic              s_excl,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [AW-1:0]     m_addr,
    output logic [2:0]        m_size,
    output logic [63:0]       m_data,
    output logic [7:0]        m_strb,
    output logic              m_last,
    output logic              m_cache,
    output logic              m_excl,
    input  logic              m_bvalid,
    output logic              m_bready,
    input  logic [1:0]        m_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [1:0]        s_bresp
);
    logic q_done, q_byp, rq_full, take;

    nwp_packer #(.IN_W(IN_W), .AW(AW)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .merge_off (merge_off),
        .s_valid   (s_valid),
        .s_ready   (s_ready),
        .s_addr    (s_addr),
        .s_size    (s_size),
        .s_data    (s_data),
        .s_strb    (s_strb),
        .s_last    (s_last),
        .s_cache   (s_cache),
        .s_excl    (s_excl),
        .q_done    (q_done),
        .q_take    (take),
        .q_addr    (m_addr),
        .q_size    (m_size),
        .q_data    (m_data),
        .q_strb    (m_strb),
        .q_last    (m_last),
        .q_cache   (m_cache),
        .q_excl    (m_excl),
        .q_byp     (q_byp)
    );

    // Offer a beat only when its response bookkeeping has room.
    always_comb begin
        m_valid = q_done && !rq_full;
        take    = m_valid && m_ready;
    end

    nwp_resp_fold #(.DEPTH(RQ_DEPTH)) u_fold (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take),
        .push_last (m_last),
        .push_fwd  (q_byp),
        .full      (rq_full),
        .m_bvalid  (m_bvalid),
        .m_bready  (m_bready),
        .m_bresp   (m_bresp),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_bresp   (s_bresp)
    );
endmodule

// File: rtl/nwp_checker.sv
// Protocol and rule checks for narrow_write_packer, attached by bind.
module nwp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       s_ready,
    input logic       m_valid,
    input logic       m_ready,
    input logic [2:0] m_addr_lo,
    input logic [2:0] m_size,
    input logic [63:0] m_data,
    input logic [7:0] m_strb,
    input logic       m_last,
    input logic       m_excl,
    input logic       s_bvalid,
    input logic       s_bready,
    input logic [1:0] s_bresp
);
    AST_STALL_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> !s_ready); // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_strb) && $stable(m_last))); // R8
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp))); // R8
    AST_EXCL_SOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_excl) |-> m_last); // R5
    AST_WIDE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_size == 3'd3) |-> (m_addr_lo == 3'd0)); // R9
    AST_STRB_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_size != 3'd3) |-> ($countones(m_strb) <= (1 << m_size))); // R1
endmodule

bind narrow_write_packer nwp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_ready   (s_ready),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .m_addr_lo (m_addr[2:0]),
    .m_size    (m_size),
    .m_data    (m_data),
    .m_strb    (m_strb),
    .m_last    (m_last),
    .m_excl    (m_excl),
    .s_bvalid  (s_bvalid),
    .s_bready  (s_bready),
    .s_bresp   (s_bresp)
);

// File: tb/sim_narrow_write_packer.sv
`timescale 1ns/1ps
module sim_narrow_write_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        merge_off = 1'b0;
    logic        s_valid = 1'b0, s_ready;
    logic [15:0] s_addr = '0;
    logic [2:0]  s_size = '0;
    logic [31:0] s_data = '0;
    logic [3:0]  s_strb = '0;
    logic        s_last = 1'b0, s_cache = 1'b0, s_excl = 1'b0;
    logic        m_valid, m_ready = 1'b1;
    logic [15:0] m_addr;
    logic [2:0]  m_size;
    logic [63:0] m_data;
    logic [7:0]  m_strb;
    logic        m_last, m_cache, m_excl;
    logic        m_bvalid = 1'b0, m_bready;
    logic [1:0]  m_bresp = 2'b00;
    logic        s_bvalid, s_bready = 1'b1;
    logic [1:0]  s_bresp;

    int total = 0, bad = 0;
    int out_n = 0, bdone_n = 0, up_n = 0;
    logic [15:0] o_addr [0:63];
    logic [2:0]  o_size [0:63];
    logic [63:0] o_data [0:63];
    logic [7:0]  o_strb [0:63];
    logic        o_last [0:63];
    logic        o_excl [0:63];
    logic [1:0]  plan   [0:63];
    logic [1:0]  up_r   [0:63];

    always #2.5 clk = ~clk;

    narrow_write_packer #(.IN_W(32), .AW(16), .RQ_DEPTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .merge_off(merge_off),
        .s_valid(s_valid), .s_ready(s_ready), .s_addr(s_addr), .s_size(s_size),
        .s_data(s_data), .s_strb(s_strb), .s_last(s_last), .s_cache(s_cache), .s_excl(s_excl),
        .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_size(m_size),
        .m_data(m_data), .m_strb(m_strb), .m_last(m_last), .m_cache(m_cache), .m_excl(m_excl),
        .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp)
    );

    // Monitor: record accepted wide beats, downstream and upstream responses.
    always @(posedge clk) begin
        if (rst_n && m_valid && m_ready) begin
            o_addr[out_n] = m_addr; o_size[out_n] = m_size; o_data[out_n] = m_data;
            o_strb[out_n] = m_strb; o_last[out_n] = m_last; o_excl[out_n] = m_excl;
            out_n++;
        end
        if (rst_n && m_bvalid && m_bready) bdone_n++;
        if (rst_n && s_bvalid && s_bready) begin
            up_r[up_n] = s_bresp;
            up_n++;
        end
    end

    // Downstream responder: one planned response per accepted wide beat.
    always @(negedge clk) begin
        m_bvalid = rst_n && (bdone_n < out_n);
        m_bresp  = plan[bdone_n];
    end

    task automatic chk(input string tg, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tg, act, exp);
        end
    endtask

    task automatic chk_beat(input int i, input string tg, input logic [15:0] ea, input logic [2:0] es,
                            input logic [7:0] est, input logic [63:0] emask, input logic [63:0] ed,
                            input logic el, input logic ex);
        chk({tg, " addr"}, 64'(o_addr[i]), 64'(ea));
        chk({tg, " size"}, 64'(o_size[i]), 64'(es));
        chk({tg, " strb"}, 64'(o_strb[i]), 64'(est));
        chk({tg, " data"}, o_data[i] & emask, ed);
        chk({tg, " last"}, 64'(o_last[i]), 64'(el));
        chk({tg, " excl"}, 64'(o_excl[i]), 64'(ex));
    endtask

    // Drive one narrow beat; value and strobe are given relative to the beat.
    task automatic put(input logic [15:0] a, input logic [2:0] sz, input logic [31:0] val,
                       input logic [3:0] st, input logic lst, input logic ca, input logic ex);
        @(negedge clk);
        s_valid = 1'b1; s_addr = a; s_size = sz;
        s_data = val << (8 * a[1:0]); s_strb = st << a[1:0];
        s_last = lst; s_cache = ca; s_excl = ex;
        do @(posedge clk); while (!s_ready);
    endtask

    task automatic idle_drain();
        @(negedge clk);
        s_valid = 1'b0;
        repeat (15) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 m_valid", 64'(m_valid), 64'd0);
        chk("R10 s_bvalid", 64'(s_bvalid), 64'd0);
        chk("R10 s_ready", 64'(s_ready), 64'd1);
    endtask

    task automatic t_pack_halfwords();
        int b = out_n, u = up_n;
        plan[b] = 2'b01;
        put(16'h0100, 3'd1, 32'hA1A0, 4'h3, 1'b0, 1'b1, 1'b1);
        put(16'h0102, 3'd1, 32'hB1B0, 4'h3, 1'b0, 1'b1, 1'b1);
        put(16'h0104, 3'd1, 32'hC1C0, 4'h3, 1'b0, 1'b1, 1'b1);
        put(16'h0106, 3'd1, 32'hD1D0, 4'h3, 1'b1, 1'b1, 1'b1);
        idle_drain();
        chk("R1 beat count", 64'(out_n - b), 64'd1);
        chk_beat(b, "R1 R5 R6 R9 pack", 16'h0100, 3'd3, 8'hFF, {64{1'b1}},
                 64'hD1D0_C1C0_B1B0_A1A0, 1'b1, 1'b1);
        chk("R7 resp count", 64'(up_n - u), 64'd1);
        chk("R7 exokay single", 64'(up_r[u]), 64'(2'b01));
    endtask

    task automatic t_strobe_mask();
        int b = out_n;
        plan[b] = 2'b00;
        put(16'h0201, 3'd0, 32'h11, 4'hF, 1'b0, 1'b1, 1'b0);
        put(16'h0202, 3'd0, 32'h22, 4'hF, 1'b1, 1'b1, 1'b0);
        idle_drain();
        chk("R2 flush on last count", 64'(out_n - b), 64'd1);
        chk_beat(b, "R1 R2 strobe mask", 16'h0200, 3'd3, 8'h06, 64'h0000_0000_00FF_FF00,
                 64'h0000_0000_0022_1100, 1'b1, 1'b0);
    endtask

    task automatic t_flush_rules();
        int b = out_n, u = up_n;
        plan[b] = 2'b00; plan[b+1] = 2'b00;
        put(16'h0300, 3'd2, 32'h3322_1100, 4'hF, 1'b0, 1'b1, 1'b0);
        put(16'h0308, 3'd2, 32'h7766_5544, 4'hF, 1'b1, 1'b1, 1'b0);
        idle_drain();
        chk("R2 gap count", 64'(out_n - b), 64'd2);
        chk_beat(b, "R2 R9 gap first", 16'h0300, 3'd2, 8'h0F, 64'h0000_0000_FFFF_FFFF,
                 64'h0000_0000_3322_1100, 1'b0, 1'b0);
        chk_beat(b+1, "R2 R6 gap second", 16'h0308, 3'd2, 8'h0F, 64'h0000_0000_FFFF_FFFF,
                 64'h0000_0000_7766_5544, 1'b1, 1'b0);
        chk("R7 gap resp count", 64'(up_n - u), 64'd1);
        b = out_n; u = up_n;
        plan[b] = 2'b00; plan[b+1] = 2'b10;
        put(16'h0314, 3'd2, 32'hAAAA_AAAA, 4'hF, 1'b0, 1'b1, 1'b1);
        put(16'h0318, 3'd2, 32'hBBBB_BBBB, 4'hF, 1'b0, 1'b1, 1'b1);
        put(16'h031C, 3'd2, 32'hCCCC_CCCC, 4'hF, 1'b1, 1'b1, 1'b1);
        idle_drain();
        chk("R2 lane7 count", 64'(out_n - b), 64'd2);
        chk_beat(b, "R2 R5 lane7 first", 16'h0314, 3'd2, 8'hF0, 64'hFFFF_FFFF_0000_0000,
                 64'hAAAA_AAAA_0000_0000, 1'b0, 1'b0);
        chk_beat(b+1, "R5 R9 lane7 second", 16'h0318, 3'd3, 8'hFF, {64{1'b1}},
                 64'hCCCC_CCCC_BBBB_BBBB, 1'b1, 1'b0);
        chk("R7 split resp count", 64'(up_n - u), 64'd1);
        chk("R7 slverr over okay", 64'(up_r[u]), 64'(2'b10));
    endtask

    task automatic t_noncache();
        int b = out_n, u = up_n;
        plan[b] = 2'b11; plan[b+1] = 2'b01;
        put(16'h0400, 3'd1, 32'h1234, 4'h3, 1'b0, 1'b0, 1'b1);
        put(16'h0402, 3'd1, 32'h5678, 4'h3, 1'b1, 1'b0, 1'b1);
        idle_drain();
        chk("R3 count", 64'(out_n - b), 64'd2);
        chk_beat(b, "R3 R5 first", 16'h0400, 3'd1, 8'h03, 64'h0000_0000_0000_FFFF,
                 64'h0000_0000_0000_1234, 1'b0, 1'b0);
        chk_beat(b+1, "R3 R5 second", 16'h0402, 3'd1, 8'h0C, 64'h0000_0000_FFFF_0000,
                 64'h0000_0000_5678_0000, 1'b1, 1'b0);
        chk("R7 decerr count", 64'(up_n - u), 64'd1);
        chk("R7 decerr wins", 64'(up_r[u]), 64'(2'b11));
    endtask

    task automatic t_bypass();
        int b = out_n, u = up_n;
        plan[b] = 2'b10; plan[b+1] = 2'b00;
        merge_off = 1'b1;
        put(16'h0500, 3'd1, 32'h1111, 4'h3, 1'b0, 1'b1, 1'b0);
        put(16'h0502, 3'd1, 32'h2222, 4'h3, 1'b1, 1'b1, 1'b0);
        idle_drain();
        merge_off = 1'b0;
        chk("R4 beat count", 64'(out_n - b), 64'd2);
        chk_beat(b, "R4 first", 16'h0500, 3'd1, 8'h03, 64'h0000_0000_0000_FFFF,
                 64'h0000_0000_0000_1111, 1'b0, 1'b0);
        chk_beat(b+1, "R4 second", 16'h0502, 3'd1, 8'h0C, 64'h0000_0000_FFFF_0000,
                 64'h0000_0000_2222_0000, 1'b1, 1'b0);
        chk("R4 resp count", 64'(up_n - u), 64'd2);
        chk("R4 resp first", 64'(up_r[u]), 64'(2'b10));
        chk("R4 resp second", 64'(up_r[u+1]), 64'(2'b00));
    endtask

    task automatic t_priority();
        int b = out_n, u = up_n;
        plan[b] = 2'b01; plan[b+1] = 2'b00; plan[b+2] = 2'b10; plan[b+3] = 2'b01;
        put(16'h0600, 3'd2, 32'h0, 4'hF, 1'b0, 1'b0, 1'b0);
        put(16'h0604, 3'd2, 32'h0, 4'hF, 1'b0, 1'b0, 1'b0);
        put(16'h0608, 3'd2, 32'h0, 4'hF, 1'b0, 1'b0, 1'b0);
        put(16'h060C, 3'd2, 32'h0, 4'hF, 1'b1, 1'b0, 1'b0);
        idle_drain();
        chk("R3 four beats", 64'(out_n - b), 64'd4);
        chk("R7 four fold count", 64'(up_n - u), 64'd1);
        chk("R7 slverr highest", 64'(up_r[u]), 64'(2'b10));
        b = out_n; u = up_n;
        plan[b] = 2'b00; plan[b+1] = 2'b01;
        put(16'h0610, 3'd2, 32'h0, 4'hF, 1'b0, 1'b0, 1'b0);
        put(16'h0614, 3'd2, 32'h0, 4'hF, 1'b1, 1'b0, 1'b0);
        idle_drain();
        chk("R7 okay beats exokay", 64'(up_r[u]), 64'(2'b00));
    endtask

    task automatic t_backpressure();
        int b = out_n, u = up_n;
        logic [63:0] held;
        plan[b] = 2'b10;
        m_ready = 1'b0;
        s_bready = 1'b0;
        put(16'h0700, 3'd2, 32'hFACE_CAFE, 4'hF, 1'b1, 1'b1, 1'b0);
        @(negedge clk); s_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 valid held", 64'(m_valid), 64'd1);
        chk("R8 input stalled", 64'(s_ready), 64'd0);
        held = m_data;
        repeat (3) @(negedge clk);
        chk("R8 data stable", m_data, held);
        chk("R8 nothing taken", 64'(out_n - b), 64'd0);
        m_ready = 1'b1;
        repeat (10) @(negedge clk);
        chk("R8 one beat", 64'(out_n - b), 64'd1);
        chk("R8 resp held", 64'(s_bvalid), 64'd1);
        chk("R8 resp value held", 64'(s_bresp), 64'(2'b10));
        chk("R8 resp not taken", 64'(up_n - u), 64'd0);
        s_bready = 1'b1;
        repeat (10) @(negedge clk);
        chk("R8 one resp", 64'(up_n - u), 64'd1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pack_halfwords();
        t_strobe_mask();
        t_flush_rules();
        t_noncache();
        t_bypass();
        t_priority();
        t_backpressure();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule